// File: doc/BRIEF.md
# Next-PC Selection Unit

This block owns the program counter of a single-cycle processor core. Every clock edge it loads the address of the next instruction, picked from three candidates. The first is the sequential successor, PC plus one instruction width. The second is a PC-relative branch destination. The third is an absolute jump destination formed inside the current address region. The registered PC drives the instruction memory address. The sequential successor is also presented as an output so that other logic, such as a link-register write, can use it.

The decoder supplies a branch control bit and a jump control bit. The ALU supplies its zero flag. The current instruction supplies its 16-bit immediate and its 26-bit jump field. A branch is taken only when the branch control bit and the zero flag are both high. The jump selection is placed after the branch selection, so a jump always overrides a branch.

Top module: `next_pc_unit`

## Requirements
- R1: A synchronous active-high reset loads the PC with 0x00000000 on the next rising edge, whatever the other inputs are.
- R2: With jump low and no branch taken, the PC advances by 4 on each rising edge.
- R3: `pc_plus4_o` always equals `pc_o` + 4, and bits [1:0] of `pc_o` are always zero.
- R4: With jump low, branch high and zero high, the next PC is (PC+4) + (sign-extended immediate << 2).
- R5: An immediate with bit 15 set produces a backward target, (PC+4) − 4·(2^16 − imm), modulo 2^32.
- R6: A branch that is not taken leaves the PC on the sequential path. This covers branch high with zero low, and zero high with branch low.
- R7: With jump high, the next PC is {(PC+4)[31:28], jfield[25:0], 2'b00}.
- R8: When jump and a taken branch are both present, the jump target wins.
- R9: The region bits of a jump come from PC+4 and not from PC. A jump issued at PC 0x0FFFFFFC lands in region 0x1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the PC updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imm_i | input | 16 | Branch word offset from the instruction |
| jfield_i | input | 26 | Jump word-address field from the instruction |
| branch_i | input | 1 | Decoder indicates a conditional branch |
| alu_zero_i | input | 1 | ALU result-is-zero flag |
| jump_i | input | 1 | Decoder indicates an unconditional jump |
| pc_o | output | 32 | Registered program counter |
| pc_plus4_o | output | 32 | Sequential successor of the PC |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 16-bit offset, a 26-bit jump field and a 4-byte step. These give a 4-bit region field. A jump field of all ones therefore places the PC at the last word of a region, and the next jump then shows whether the region bits come from PC or PC+4. Offsets of 0x8000 and 0x7FFF are reachable directly. Mixed random control bits cover every combination of branch, zero and jump, with both positive and negative offsets.

// File: rtl/npc_pkg.sv
package npc_pkg;
  // Source of the address loaded into the PC on the next edge
  typedef enum logic [1:0] {
    NPC_SEQ    = 2'd0,
    NPC_BRANCH = 2'd1,
    NPC_JUMP   = 2'd2
  } npc_src_e;
endpackage

// File: rtl/npc_seq_adder.sv
module npc_seq_adder #(
  parameter int ADDR_W     = 32,
  parameter int STEP_BYTES = 4
) (
  input  logic [ADDR_W-1:0] pc_i,
  output logic [ADDR_W-1:0] seq_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STEP_BYTES);

  always_comb seq_o = pc_i + STEP;
endmodule

// File: rtl/npc_branch_target.sv
module npc_branch_target #(
  parameter int ADDR_W  = 32,
  parameter int IMM_W   = 16,
  parameter int ALIGN_W = 2
) (
  input  logic [ADDR_W-1:0] seq_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [ADDR_W-1:0] target_o
);
  localparam int EXT_W = ADDR_W - IMM_W - ALIGN_W;

  logic [ADDR_W-1:0] offset;

  // Sign extension must happen before scaling so that negative offsets point backward
  generate
    if (ALIGN_W > 0) begin : g_scaled
      always_comb offset = {{EXT_W{imm_i[IMM_W-1]}}, imm_i, {ALIGN_W{1'b0}}};
    end else begin : g_unscaled
      always_comb offset = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
    end
  endgenerate

  always_comb target_o = seq_i + offset;
endmodule

// File: rtl/npc_jump_target.sv
module npc_jump_target #(
  parameter int ADDR_W   = 32,
  parameter int JFIELD_W = 26,
  parameter int ALIGN_W  = 2
) (
  input  logic [ADDR_W-JFIELD_W-ALIGN_W-1:0] region_i,
  input  logic [JFIELD_W-1:0]                jfield_i,
  output logic [ADDR_W-1:0]                  target_o
);
  generate
    if (ALIGN_W > 0) begin : g_aligned
      always_comb target_o = {region_i, jfield_i, {ALIGN_W{1'b0}}};
    end else begin : g_byte
      always_comb target_o = {region_i, jfield_i};
    end
  endgenerate
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] seq_i,
  input  logic [ADDR_W-1:0] branch_tgt_i,
  input  logic [ADDR_W-1:0] jump_tgt_i,
  input  logic              branch_i,
  input  logic              zero_i,
  input  logic              jump_i,
  output npc_src_e          src_o,
  output logic [ADDR_W-1:0] next_o
);
  logic              take_branch;
  logic [ADDR_W-1:0] after_branch;

  always_comb begin
    take_branch  = branch_i & zero_i;
    after_branch = take_branch ? branch_tgt_i : seq_i;
    // The jump mux is placed after the branch mux, so a jump overrides a branch
    next_o       = jump_i ? jump_tgt_i : after_branch;
    if (jump_i)           src_o = NPC_JUMP;
    else if (take_branch) src_o = NPC_BRANCH;
    else                  src_o = NPC_SEQ;
  end
endmodule

// File: rtl/next_pc_unit.sv
module next_pc_unit
  import npc_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter int                IMM_W      = 16,
  parameter int                JFIELD_W   = 26,
  parameter int                STEP_BYTES = 4,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [IMM_W-1:0]    imm_i,
  input  logic [JFIELD_W-1:0] jfield_i,
  input  logic                branch_i,
  input  logic                alu_zero_i,
  input  logic                jump_i,
  output logic [ADDR_W-1:0]   pc_o,
  output logic [ADDR_W-1:0]   pc_plus4_o
);
  localparam int ALIGN_W  = $clog2(STEP_BYTES);
  localparam int REGION_W = ADDR_W - JFIELD_W - ALIGN_W;

  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] seq_pc;
  logic [ADDR_W-1:0] br_tgt;
  logic [ADDR_W-1:0] jmp_tgt;
  logic [ADDR_W-1:0] next_pc;
  npc_src_e          src;

  npc_seq_adder #(.ADDR_W(ADDR_W), .STEP_BYTES(STEP_BYTES)) u_seq (
    .pc_i (pc_q),
    .seq_o(seq_pc)
  );

  npc_branch_target #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .ALIGN_W(ALIGN_W)) u_br (
    .seq_i   (seq_pc),
    .imm_i   (imm_i),
    .target_o(br_tgt)
  );

  npc_jump_target #(.ADDR_W(ADDR_W), .JFIELD_W(JFIELD_W), .ALIGN_W(ALIGN_W)) u_jmp (
    .region_i(seq_pc[ADDR_W-1 -: REGION_W]),
    .jfield_i(jfield_i),
    .target_o(jmp_tgt)
  );

  npc_select #(.ADDR_W(ADDR_W)) u_sel (
    .seq_i       (seq_pc),
    .branch_tgt_i(br_tgt),
    .jump_tgt_i  (jmp_tgt),
    .branch_i    (branch_i),
    .zero_i      (alu_zero_i),
    .jump_i      (jump_i),
    .src_o       (src),
    .next_o      (next_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_ADDR;
    else     pc_q <= next_pc;
  end

  assign pc_o       = pc_q;
  assign pc_plus4_o = seq_pc;

  // R1: reset forces the start address on the following edge
  p_reset_load_r1: assert property (@(posedge clk) rst |=> pc_q == RESET_ADDR);

  // R2: with no redirection the PC moves by one step
  p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!jump_i && !(branch_i && alu_zero_i)) |=> pc_q == $past(pc_q) + ADDR_W'(STEP_BYTES));

  // R3: the PC stays aligned to an instruction boundary
  p_aligned_r3: assert property (@(posedge clk) disable iff (rst)
    pc_q[ALIGN_W-1:0] == '0);

  // R4: the selector chooses the branch source only when the branch is taken and no jump
  p_branch_src_r4: assert property (@(posedge clk) disable iff (rst)
    (src == NPC_BRANCH) |-> (branch_i && alu_zero_i && !jump_i));

  // R7: after a jump the field bits of the PC hold the jump field
  p_jump_field_r7: assert property (@(posedge clk) disable iff (rst)
    jump_i |=> pc_q[ADDR_W-REGION_W-1:ALIGN_W] == $past(jfield_i));

  // R9: after a jump the region bits of the PC come from the sequential successor
  p_jump_region_r9: assert property (@(posedge clk) disable iff (rst)
    jump_i |=> pc_q[ADDR_W-1 -: REGION_W] == $past(seq_pc[ADDR_W-1 -: REGION_W]));

  // R8: a jump always takes precedence over the branch path
  p_jump_wins_r8: assert property (@(posedge clk) disable iff (rst)
    jump_i |-> src == NPC_JUMP);
endmodule

// File: tb/next_pc_unit_test.sv
module next_pc_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] imm_i = '0;
  logic [25:0] jfield_i = '0;
  logic        branch_i = 1'b0;
  logic        alu_zero_i = 1'b0;
  logic        jump_i = 1'b0;
  logic [31:0] pc_o;
  logic [31:0] pc_plus4_o;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  logic [31:0] model_pc = '0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  next_pc_unit uut (
    .clk(clk), .rst(rst), .imm_i(imm_i), .jfield_i(jfield_i),
    .branch_i(branch_i), .alu_zero_i(alu_zero_i), .jump_i(jump_i),
    .pc_o(pc_o), .pc_plus4_o(pc_plus4_o)
  );

  function automatic logic [31:0] ref_next(input logic [31:0] pc, input logic [15:0] imm,
                                           input logic [25:0] jf, input logic br,
                                           input logic z, input logic j);
    logic [31:0] s;
    s = pc + 32'd4;
    if (j)           return {s[31:28], jf, 2'b00};
    else if (br && z) return s + {{14{imm[15]}}, imm, 2'b00};
    else             return s;
  endfunction

  function automatic string req_of(input logic [15:0] imm, input logic br,
                                   input logic z, input logic j);
    if (j)           return (br && z) ? "R8" : "R7";
    else if (br && z) return imm[15] ? "R5" : "R4";
    else if (br || z) return "R6";
    else             return "R2";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Called at a falling edge: drive, wait one full cycle, check
  task automatic step(input logic [15:0] imm, input logic [25:0] jf, input logic br,
                      input logic z, input logic j, input string req);
    logic [31:0] exp;
    imm_i = imm; jfield_i = jf; branch_i = br; alu_zero_i = z; jump_i = j;
    exp = ref_next(model_pc, imm, jf, br, z, j);
    @(negedge clk);
    check(req, pc_o, exp);
    check("R3", pc_plus4_o, exp + 32'd4);
    model_pc = exp;
  endtask

  task automatic do_reset();
    rst = 1'b1; jump_i = 1'b1; jfield_i = 26'h155_5555; branch_i = 1'b1; alu_zero_i = 1'b1;
    @(negedge clk);
    check("R1", pc_o, 32'h0);
    check("R3", pc_plus4_o, 32'h4);
    rst = 1'b0;
    model_pc = '0;
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    @(negedge clk);
    do_reset();
    // R2: plain sequential run
    for (int i = 0; i < 4; i++) step(16'h1234, 26'h0, 1'b0, 1'b0, 1'b0, "R2");
    // R6: branch without zero, zero without branch
    step(16'h0040, 26'h0, 1'b1, 1'b0, 1'b0, "R6");
    step(16'h0040, 26'h0, 1'b0, 1'b1, 1'b0, "R6");
    // R4: forward branch, largest positive offset
    step(16'h0010, 26'h0, 1'b1, 1'b1, 1'b0, "R4");
    step(16'h7FFF, 26'h0, 1'b1, 1'b1, 1'b0, "R4");
    // R5: backward branches, including most negative offset and -1
    step(16'hFFFF, 26'h0, 1'b1, 1'b1, 1'b0, "R5");
    step(16'h8000, 26'h0, 1'b1, 1'b1, 1'b0, "R5");
    // R7: jump; R8: jump with taken branch
    step(16'h0000, 26'h000_0100, 1'b0, 1'b0, 1'b1, "R7");
    step(16'h0020, 26'h0AB_CDEF, 1'b1, 1'b1, 1'b1, "R8");
    // R9: jump to last word of region 0, then jump again from there
    step(16'h0000, 26'h3FF_FFFF, 1'b0, 1'b0, 1'b1, "R7");
    check("R9", pc_o, 32'h0FFF_FFFC);
    step(16'h0000, 26'h000_0008, 1'b0, 1'b0, 1'b1, "R9");
    check("R9", pc_o, 32'h1000_0020);
    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] r_imm;
      logic [25:0] r_jf;
      logic r_br, r_z, r_j;
      r_imm = 16'($urandom);
      r_jf  = 26'($urandom);
      r_br  = ($urandom % 2) == 0;
      r_z   = ($urandom % 2) == 0;
      r_j   = ($urandom % 5) == 0;
      step(r_imm, r_jf, r_br, r_z, r_j, req_of(r_imm, r_br, r_z, r_j));
      if (i == 1500) begin
        do_reset();
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule